// File: doc/BRIEF.md
# DRAM-Cache Row Metadata Buffer

This block sits in a memory controller in front of a direct-mapped DRAM cache whose tags are stored inside the DRAM rows, next to the data blocks they describe. A small on-chip table, direct-mapped on the low bits of the DRAM row number, keeps copies of the complete tag set of recently touched rows. Each request address is looked up in this table. If the row's tags are present, the cache hit/miss answer is given at once, with no metadata traffic to DRAM. If they are not present, the block issues one metadata read for the row and installs the returned tags in the table, overwriting whatever row was there. It then gives the answer, marking the access as one that will find the row already open.

Requests are taken one at a time through a valid/ready handshake. A separate fill port reports every install of a block into the DRAM cache, so the buffered copy of a row is patched in the same cycle that its tags change. Data movement, backing-memory timing and the migration policy are handled elsewhere.

Top module: `row_meta_cache`

## Requirements
- R1: After reset every table entry is invalid, `req_ready` is 1, and `res_valid` and `meta_req_valid` are 0. The first request to any row therefore causes a metadata fetch.
- R2: With the default parameters, a request address splits as follows: byte offset [6:0] (128-byte blocks), block-in-row index [8:7], DRAM row [17:9] and cache tag [23:18]. The table index is row[5:0] and the stored row tag is row[8:6].
- R3: A request whose row is present in the table produces `res_valid` in the cycle after it is accepted, with `res_row_open`=0 and no metadata read.
- R4: A request whose row is absent pulses `meta_req_valid` for exactly one cycle, in the cycle after acceptance, with `meta_req_row` equal to the request row. `req_ready` stays 0 from acceptance until the result appears.
- R5: In the metadata response, block b occupies bits [7b+6:7b]: bit 7b+6 is the block-valid flag and bits [7b+5:7b] are the cache tag. A response accepted while waiting replaces the table entry and produces the result in the next cycle with `res_row_open`=1. The hit/miss answer is taken from the returned tags.
- R6: `res_hit` is 1 exactly when the addressed block's slot is valid and its tag equals the request's cache tag. `res_blk` gives the block-in-row index and `res_write` echoes the request's write flag.
- R7: Two rows with the same table index evict each other, so going back to the evicted row fetches its metadata again.
- R8: A fill for a row held in the table writes the new tag into that block's slot and marks the slot valid in the same cycle. A later request to that block then hits with no fetch.
- R9: A fill for a row that is not held in the table leaves the table unchanged. This includes the case where another row occupies the same index.
- R10: A metadata response that arrives while no fetch is outstanding is ignored. It produces no result and does not change the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W (24) | Request byte address |
| req_write | input | 1 | Request is a write |
| meta_req_valid | output | 1 | One-cycle metadata read command |
| meta_req_row | output | ROW_W (9) | Row whose metadata is read |
| meta_rsp_valid | input | 1 | Metadata response present |
| meta_rsp_data | input | META_W (28) | Tag slots of the fetched row |
| fill_valid | input | 1 | A block was installed in the DRAM cache |
| fill_row | input | ROW_W (9) | Row of the installed block |
| fill_blk | input | BLK_W (2) | Block-in-row index of the installed block |
| fill_tag | input | CTAG_W (6) | Cache tag of the installed block |
| res_valid | output | 1 | Result present (one cycle) |
| res_hit | output | 1 | DRAM-cache hit |
| res_blk | output | BLK_W (2) | Block-in-row index of the request |
| res_write | output | 1 | Write flag of the request |
| res_row_open | output | 1 | Metadata was fetched, so the data access finds the row open |

## Verification
On every cycle, the assertions check the control timing. A present row must answer one cycle after acceptance with no metadata read. An absent row must raise a single-cycle fetch while ready is low. An accepted response must yield a row-open result. A stray response must yield nothing. A refilled entry must become valid. Whether the hit/miss answer, the block index and the tag contents are right can only be shown by the bench scenarios, which compare them with a reference table and a model of the DRAM rows. The same goes for index conflicts, fills to present and absent rows, and ignored responses.

// File: rtl/rmc_pkg.sv
// Shared types for the row metadata buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package rmc_pkg;

    // Controller state: free to take a request, or waiting on a metadata read
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } rmc_state_e;

endpackage

// File: rtl/rmc_addr_split.sv
// Splits a request byte address into cache tag, row, block-in-row index,
// table index and stored row tag.
// Assumes: ADDR_W >= OFF_W + BLK_W + ROW_W + 1 and IDX_W < ROW_W.
module rmc_addr_split #(
    parameter int ADDR_W = 24,
    parameter int OFF_W  = 7,
    parameter int BLK_W  = 2,
    parameter int ROW_W  = 9,
    parameter int IDX_W  = 6,
    localparam int CTAG_W = ADDR_W - OFF_W - BLK_W - ROW_W,
    localparam int RTAG_W = ROW_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CTAG_W-1:0] ctag,
    output logic [ROW_W-1:0]  row,
    output logic [BLK_W-1:0]  blk,
    output logic [IDX_W-1:0]  idx,
    output logic [RTAG_W-1:0] rtag
);

    // Field extraction, highest field is the cache tag
    always_comb begin
        blk  = addr[OFF_W +: BLK_W];
        row  = addr[OFF_W+BLK_W +: ROW_W];
        ctag = addr[ADDR_W-1 -: CTAG_W];
        idx  = row[IDX_W-1:0];
        rtag = row[ROW_W-1:IDX_W];
    end

endmodule

// File: rtl/rmc_entry_array.sv
// Direct-mapped table of row metadata. Each entry holds a valid bit, the
// upper row bits and one tag slot per block of the row.
// Read is combinational. Refill overwrites a whole entry. A fill patches one
// slot of an entry only when that entry holds the filled row.
// Assumes: refill and fill to the same entry in one cycle resolve in favour
// of the refill.
module rmc_entry_array #(
    parameter int ENTRIES = 64,
    parameter int ROW_W   = 9,
    parameter int BLK_W   = 2,
    parameter int CTAG_W  = 6,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int RTAG_W = ROW_W - IDX_W,
    localparam int BLKS   = 2 ** BLK_W,
    localparam int SLOT_W = CTAG_W + 1,
    localparam int META_W = BLKS * SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [RTAG_W-1:0] rd_rtag,
    output logic [META_W-1:0] rd_meta,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [RTAG_W-1:0] wr_rtag,
    input  logic [META_W-1:0] wr_meta,
    input  logic              fill_en,
    input  logic [ROW_W-1:0]  fill_row,
    input  logic [BLK_W-1:0]  fill_blk,
    input  logic [CTAG_W-1:0] fill_tag
);

    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][RTAG_W-1:0] ent_rtag;
    logic [ENTRIES-1:0][META_W-1:0] ent_meta;

    logic [IDX_W-1:0]  fill_idx;
    logic [RTAG_W-1:0] fill_rtag;
    assign fill_idx  = fill_row[IDX_W-1:0];
    assign fill_rtag = fill_row[ROW_W-1:IDX_W];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic              v_q;
        logic [RTAG_W-1:0] t_q;
        logic              sel_wr;
        logic              sel_fill;

        assign sel_wr   = wr_en && (wr_idx == IDX_W'(e));
        assign sel_fill = fill_en && (fill_idx == IDX_W'(e)) && v_q && (t_q == fill_rtag);

        // Entry valid bit and row tag: cleared on reset, set by refill
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                t_q <= '0;
            end else if (sel_wr) begin
                v_q <= 1'b1;
                t_q <= wr_rtag;
            end
        end

        for (genvar b = 0; b < BLKS; b++) begin : g_slot
            logic [SLOT_W-1:0] s_q;

            // Slot storage: refill loads it, a matching fill patches it
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s_q <= '0;
                end else if (sel_wr) begin
                    s_q <= wr_meta[b*SLOT_W +: SLOT_W];
                end else if (sel_fill && (fill_blk == BLK_W'(b))) begin
                    s_q <= {1'b1, fill_tag};
                end
            end

            assign ent_meta[e][b*SLOT_W +: SLOT_W] = s_q;
        end

        assign ent_valid[e] = v_q;
        assign ent_rtag[e]  = t_q;
    end

    // Combinational read port
    always_comb begin
        rd_valid = ent_valid[rd_idx];
        rd_rtag  = ent_rtag[rd_idx];
        rd_meta  = ent_meta[rd_idx];
    end

    // R5: a refilled entry is valid in the following cycle
    p_refill_sets_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ent_valid[$past(wr_idx)]);

    // R9: a fill never validates an entry
    p_fill_keeps_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !wr_en) |=> ($countones(ent_valid) == $countones($past(ent_valid))));

endmodule

// File: rtl/rmc_slot_match.sv
// Selects the addressed block's slot from a row's metadata and compares it
// with the request's cache tag.
// Assumes: slot layout {valid, tag}, block b at bits [b*SLOT_W +: SLOT_W].
module rmc_slot_match #(
    parameter int BLK_W  = 2,
    parameter int CTAG_W = 6,
    localparam int BLKS   = 2 ** BLK_W,
    localparam int SLOT_W = CTAG_W + 1,
    localparam int META_W = BLKS * SLOT_W
) (
    input  logic [META_W-1:0] meta,
    input  logic [BLK_W-1:0]  blk,
    input  logic [CTAG_W-1:0] ctag,
    output logic              hit
);

    logic [SLOT_W-1:0] slots [BLKS];

    for (genvar b = 0; b < BLKS; b++) begin : g_unpack
        assign slots[b] = meta[b*SLOT_W +: SLOT_W];
    end

    // Hit needs a valid slot holding the same tag
    always_comb begin
        hit = slots[blk][SLOT_W-1] && (slots[blk][CTAG_W-1:0] == ctag);
    end

endmodule

// File: rtl/rmc_ctrl.sv
// Request sequencer. Takes one request at a time. A present row answers in
// the next cycle. An absent row issues one metadata read, waits for the
// response, triggers the refill and then answers with row-open set.
// Assumes: buf_hit and slot_hit are valid in the cycle a request is offered
// (idle) and in the cycle the response arrives (waiting).
module rmc_ctrl
    import rmc_pkg::*;
#(
    parameter int ROW_W  = 9,
    parameter int BLK_W  = 2,
    parameter int CTAG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [BLK_W-1:0]  req_blk,
    input  logic [CTAG_W-1:0] req_ctag,
    input  logic              req_write,
    input  logic              buf_hit,
    input  logic              slot_hit,
    input  logic              meta_rsp_valid,
    output logic              req_ready,
    output logic              in_wait,
    output logic              refill_en,
    output logic [ROW_W-1:0]  h_row,
    output logic [BLK_W-1:0]  h_blk,
    output logic [CTAG_W-1:0] h_ctag,
    output logic              meta_req_valid,
    output logic [ROW_W-1:0]  meta_req_row,
    output logic              res_valid,
    output logic              res_hit,
    output logic [BLK_W-1:0]  res_blk,
    output logic              res_write,
    output logic              res_row_open
);

    rmc_state_e state_q;
    logic       h_write;

    assign in_wait   = (state_q == ST_WAIT);
    assign req_ready = (state_q == ST_IDLE);
    assign refill_en = in_wait && meta_rsp_valid;

    // State, held request and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= ST_IDLE;
            h_row          <= '0;
            h_blk          <= '0;
            h_ctag         <= '0;
            h_write        <= 1'b0;
            meta_req_valid <= 1'b0;
            meta_req_row   <= '0;
            res_valid      <= 1'b0;
            res_hit        <= 1'b0;
            res_blk        <= '0;
            res_write      <= 1'b0;
            res_row_open   <= 1'b0;
        end else begin
            res_valid      <= 1'b0;
            meta_req_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        h_row   <= req_row;
                        h_blk   <= req_blk;
                        h_ctag  <= req_ctag;
                        h_write <= req_write;
                        if (buf_hit) begin
                            res_valid    <= 1'b1;
                            res_hit      <= slot_hit;
                            res_blk      <= req_blk;
                            res_write    <= req_write;
                            res_row_open <= 1'b0;
                        end else begin
                            meta_req_valid <= 1'b1;
                            meta_req_row   <= req_row;
                            state_q        <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (meta_rsp_valid) begin
                        res_valid    <= 1'b1;
                        res_hit      <= slot_hit;
                        res_blk      <= h_blk;
                        res_write    <= h_write;
                        res_row_open <= 1'b1;
                        state_q      <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3: present row answers next cycle without a metadata read
    p_hit_no_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && buf_hit) |=> (res_valid && !res_row_open && !meta_req_valid));

    // R4: absent row fetches and blocks further requests
    p_miss_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !buf_hit) |=> (meta_req_valid && !req_ready && !res_valid
                                                  && meta_req_row == $past(req_row)));

    // R4: the metadata command is a single-cycle pulse
    p_meta_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        meta_req_valid |=> !meta_req_valid);

    // R5: an accepted response yields a row-open result and frees the port
    p_refill_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && meta_rsp_valid) |=> (res_valid && res_row_open && req_ready));

    // R10: a response with nothing outstanding produces no result
    p_stray_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && meta_rsp_valid && !req_valid) |=> !res_valid);

endmodule

// File: rtl/row_meta_cache.sv
// Top of the DRAM-cache row metadata buffer. Connects the address split, the
// entry table, the slot matcher and the request sequencer. The matcher reads
// the table while idle and the incoming response while waiting, so a refill
// answers from the fetched tags in the same cycle they are written.
// Assumes: BLK_BYTES, BLKS_PER_ROW, ROWS and ENTRIES are powers of two.
module row_meta_cache #(
    parameter int ADDR_W       = 24,
    parameter int BLK_BYTES    = 128,
    parameter int BLKS_PER_ROW = 4,
    parameter int ROWS         = 512,
    parameter int ENTRIES      = 64,
    localparam int OFF_W  = $clog2(BLK_BYTES),
    localparam int BLK_W  = $clog2(BLKS_PER_ROW),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int RTAG_W = ROW_W - IDX_W,
    localparam int CTAG_W = ADDR_W - OFF_W - BLK_W - ROW_W,
    localparam int META_W = BLKS_PER_ROW * (CTAG_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              meta_req_valid,
    output logic [ROW_W-1:0]  meta_req_row,
    input  logic              meta_rsp_valid,
    input  logic [META_W-1:0] meta_rsp_data,
    input  logic              fill_valid,
    input  logic [ROW_W-1:0]  fill_row,
    input  logic [BLK_W-1:0]  fill_blk,
    input  logic [CTAG_W-1:0] fill_tag,
    output logic              res_valid,
    output logic              res_hit,
    output logic [BLK_W-1:0]  res_blk,
    output logic              res_write,
    output logic              res_row_open
);

    logic [CTAG_W-1:0] q_ctag;
    logic [ROW_W-1:0]  q_row;
    logic [BLK_W-1:0]  q_blk;
    logic [IDX_W-1:0]  q_idx;
    logic [RTAG_W-1:0] q_rtag;

    logic              rd_valid;
    logic [RTAG_W-1:0] rd_rtag;
    logic [META_W-1:0] rd_meta;

    logic              in_wait;
    logic              refill_en;
    logic [ROW_W-1:0]  h_row;
    logic [BLK_W-1:0]  h_blk;
    logic [CTAG_W-1:0] h_ctag;

    logic              buf_hit;
    logic              slot_hit;
    logic [META_W-1:0] cmp_meta;
    logic [BLK_W-1:0]  cmp_blk;
    logic [CTAG_W-1:0] cmp_ctag;

    rmc_addr_split #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .BLK_W  (BLK_W),
        .ROW_W  (ROW_W),
        .IDX_W  (IDX_W)
    ) u_split (
        .addr (req_addr),
        .ctag (q_ctag),
        .row  (q_row),
        .blk  (q_blk),
        .idx  (q_idx),
        .rtag (q_rtag)
    );

    rmc_entry_array #(
        .ENTRIES (ENTRIES),
        .ROW_W   (ROW_W),
        .BLK_W   (BLK_W),
        .CTAG_W  (CTAG_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (q_idx),
        .rd_valid (rd_valid),
        .rd_rtag  (rd_rtag),
        .rd_meta  (rd_meta),
        .wr_en    (refill_en),
        .wr_idx   (h_row[IDX_W-1:0]),
        .wr_rtag  (h_row[ROW_W-1:IDX_W]),
        .wr_meta  (meta_rsp_data),
        .fill_en  (fill_valid),
        .fill_row (fill_row),
        .fill_blk (fill_blk),
        .fill_tag (fill_tag)
    );

    // Table presence for the offered request
    assign buf_hit = rd_valid && (rd_rtag == q_rtag);

    // Compare source: table while idle, fetched tags while waiting
    always_comb begin
        cmp_meta = in_wait ? meta_rsp_data : rd_meta;
        cmp_blk  = in_wait ? h_blk         : q_blk;
        cmp_ctag = in_wait ? h_ctag        : q_ctag;
    end

    rmc_slot_match #(
        .BLK_W  (BLK_W),
        .CTAG_W (CTAG_W)
    ) u_match (
        .meta (cmp_meta),
        .blk  (cmp_blk),
        .ctag (cmp_ctag),
        .hit  (slot_hit)
    );

    rmc_ctrl #(
        .ROW_W  (ROW_W),
        .BLK_W  (BLK_W),
        .CTAG_W (CTAG_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_row        (q_row),
        .req_blk        (q_blk),
        .req_ctag       (q_ctag),
        .req_write      (req_write),
        .buf_hit        (buf_hit),
        .slot_hit       (slot_hit),
        .meta_rsp_valid (meta_rsp_valid),
        .req_ready      (req_ready),
        .in_wait        (in_wait),
        .refill_en      (refill_en),
        .h_row          (h_row),
        .h_blk          (h_blk),
        .h_ctag         (h_ctag),
        .meta_req_valid (meta_req_valid),
        .meta_req_row   (meta_req_row),
        .res_valid      (res_valid),
        .res_hit        (res_hit),
        .res_blk        (res_blk),
        .res_write      (res_write),
        .res_row_open   (res_row_open)
    );

    // R2: the fetched row is the row field of the accepted address
    p_fetch_row_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !buf_hit) |=> (meta_req_row == $past(req_addr[OFF_W+BLK_W +: ROW_W])));

endmodule

// File: tb/row_meta_cache_tb.sv
// Self-checking bench: a reference table plus a model of the per-row tags in
// DRAM. Directed corner cases are followed by seeded random traffic.
module row_meta_cache_tb;

    localparam int ADDR_W = 24;
    localparam int ROW_W  = 9;
    localparam int BLK_W  = 2;
    localparam int CTAG_W = 6;
    localparam int META_W = 28;
    localparam int NROWS  = 512;
    localparam int NENT   = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_write = 1'b0;
    logic              meta_req_valid;
    logic [ROW_W-1:0]  meta_req_row;
    logic              meta_rsp_valid = 1'b0;
    logic [META_W-1:0] meta_rsp_data = '0;
    logic              fill_valid = 1'b0;
    logic [ROW_W-1:0]  fill_row = '0;
    logic [BLK_W-1:0]  fill_blk = '0;
    logic [CTAG_W-1:0] fill_tag = '0;
    logic              res_valid;
    logic              res_hit;
    logic [BLK_W-1:0]  res_blk;
    logic              res_write;
    logic              res_row_open;

    always #10 clk = ~clk;

    row_meta_cache u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_addr       (req_addr),
        .req_write      (req_write),
        .meta_req_valid (meta_req_valid),
        .meta_req_row   (meta_req_row),
        .meta_rsp_valid (meta_rsp_valid),
        .meta_rsp_data  (meta_rsp_data),
        .fill_valid     (fill_valid),
        .fill_row       (fill_row),
        .fill_blk       (fill_blk),
        .fill_tag       (fill_tag),
        .res_valid      (res_valid),
        .res_hit        (res_hit),
        .res_blk        (res_blk),
        .res_write      (res_write),
        .res_row_open   (res_row_open)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    logic [META_W-1:0] dmeta [NROWS];
    logic              m_valid [NENT];
    logic [2:0]        m_rtag [NENT];
    logic [META_W-1:0] m_meta [NENT];
    bit                last_fetched;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_hit(input logic [META_W-1:0] m, input logic [1:0] b, input logic [5:0] t);
        logic [6:0] s;
        s = 7'((m >> (b * 7)) & 28'h7f);
        return s[6] && (s[5:0] == t);
    endfunction

    function automatic logic [ADDR_W-1:0] mk_addr(input logic [5:0] t, input logic [8:0] r,
                                                  input logic [1:0] b, input logic [6:0] o);
        return {t, r, b, o};
    endfunction

    // One request, checked on both the table-hit and the fetch path
    task automatic do_req(input logic [ADDR_W-1:0] a, input bit w);
        logic [8:0] row;
        logic [1:0] blk;
        logic [5:0] ct;
        logic [5:0] idx;
        bit         bh;
        bit         eh;
        int         lag;
        row = a[17:9];
        blk = a[8:7];
        ct  = a[23:18];
        idx = row[5:0];
        bh  = m_valid[idx] && (m_rtag[idx] == row[8:6]);
        @(negedge clk);
        chk(req_ready == 1'b1, "R4 ready before request", 32'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = a;
        req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        last_fetched = meta_req_valid;
        if (bh) begin
            eh = exp_hit(m_meta[idx], blk, ct);
            chk(res_valid && !res_row_open && !meta_req_valid, "R3 table hit answers at once",
                {29'd0, res_valid, res_row_open, meta_req_valid}, 32'h4);
            chk(res_hit == eh, "R6 hit decision from table", 32'(res_hit), 32'(eh));
            chk(res_blk == blk && res_write == w, "R6 block index and write flag",
                {29'd0, res_write, res_blk}, {29'd0, w, blk});
        end else begin
            eh = exp_hit(dmeta[row], blk, ct);
            chk(meta_req_valid && meta_req_row == row && !res_valid, "R4 fetch issued for absent row",
                {21'd0, meta_req_valid, res_valid, meta_req_row}, {21'd0, 2'b10, row});
            lag = int'($urandom % 3);
            for (int k = 0; k < lag; k++) begin
                @(negedge clk);
                chk(!req_ready && !meta_req_valid && !res_valid, "R4 blocked while fetching",
                    {29'd0, req_ready, meta_req_valid, res_valid}, 0);
            end
            meta_rsp_valid = 1'b1;
            meta_rsp_data  = dmeta[row];
            @(negedge clk);
            meta_rsp_valid = 1'b0;
            meta_rsp_data  = '0;
            chk(res_valid && res_row_open && req_ready, "R5 refill result flagged row open",
                {29'd0, res_valid, res_row_open, req_ready}, 32'h7);
            chk(res_hit == eh, "R5 hit decision from fetched tags", 32'(res_hit), 32'(eh));
            chk(res_blk == blk && res_write == w, "R6 block index and write flag",
                {29'd0, res_write, res_blk}, {29'd0, w, blk});
            m_valid[idx] = 1'b1;
            m_rtag[idx]  = row[8:6];
            m_meta[idx]  = dmeta[row];
        end
    endtask

    // A block install: DRAM row model always, table model only if present
    task automatic do_fill(input logic [8:0] r, input logic [1:0] b, input logic [5:0] t);
        logic [5:0] idx;
        idx = r[5:0];
        @(negedge clk);
        fill_valid = 1'b1;
        fill_row   = r;
        fill_blk   = b;
        fill_tag   = t;
        @(negedge clk);
        fill_valid = 1'b0;
        dmeta[r][b*7 +: 7] = {1'b1, t};
        if (m_valid[idx] && m_rtag[idx] == r[8:6])
            m_meta[idx][b*7 +: 7] = {1'b1, t};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [5:0] tx;
        logic [8:0] rr;
        void'($urandom(32'd20240611));
        for (int r = 0; r < NROWS; r++) dmeta[r] = META_W'($urandom);
        for (int e = 0; e < NENT; e++) begin
            m_valid[e] = 1'b0;
            m_rtag[e]  = '0;
            m_meta[e]  = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready && !res_valid && !meta_req_valid, "R1 reset outputs",
            {29'd0, req_ready, res_valid, meta_req_valid}, 32'h4);

        // R1 and R2: first access fetches, offset bits do not change the row
        dmeta[9'h045][1*7 +: 7] = {1'b1, 6'h2a};
        do_req(mk_addr(6'h2a, 9'h045, 2'd1, 7'h00), 1'b0);
        chk(last_fetched, "R1 first access fetches", 32'(last_fetched), 1);
        chk(res_hit == 1'b1, "R2 tag field bits 23:18", 32'(res_hit), 1);
        do_req(mk_addr(6'h2a, 9'h045, 2'd1, 7'h7f), 1'b1);
        chk(!last_fetched, "R2 offset bits ignored for row", 32'(last_fetched), 0);
        do_req(mk_addr(6'h11, 9'h045, 2'd3, 7'h10), 1'b0);

        // R7: same index, different row tag evicts
        do_req(mk_addr(6'h01, 9'h085, 2'd0, 7'h00), 1'b0);
        chk(last_fetched, "R7 conflicting row fetches", 32'(last_fetched), 1);
        do_req(mk_addr(6'h2a, 9'h045, 2'd1, 7'h00), 1'b0);
        chk(last_fetched, "R7 evicted row fetched again", 32'(last_fetched), 1);

        // R8: fill to present row is visible without fetch
        do_fill(9'h045, 2'd2, 6'h15);
        do_req(mk_addr(6'h15, 9'h045, 2'd2, 7'h00), 1'b0);
        chk(!last_fetched && res_hit, "R8 fill patched present entry",
            {30'd0, last_fetched, res_hit}, 32'h1);

        // R9: fill to an absent row sharing the index leaves the entry alone
        tx = dmeta[9'h045][5:0] ^ 6'h01;
        do_fill(9'h0c5, 2'd0, tx);
        do_req(mk_addr(tx, 9'h045, 2'd0, 7'h00), 1'b0);
        chk(!last_fetched && !res_hit, "R9 absent-row fill ignored",
            {30'd0, last_fetched, res_hit}, 0);

        // R10: stray response while idle
        @(negedge clk);
        meta_rsp_valid = 1'b1;
        meta_rsp_data  = '1;
        @(negedge clk);
        meta_rsp_valid = 1'b0;
        meta_rsp_data  = '0;
        chk(!res_valid && req_ready, "R10 stray response no result",
            {30'd0, res_valid, req_ready}, 1);
        do_req(mk_addr(6'h3f, 9'h045, 2'd3, 7'h00), 1'b0);
        chk(!last_fetched, "R10 entry unchanged by stray response", 32'(last_fetched), 0);

        // Random traffic over a small row pool to provoke hits and conflicts
        for (int i = 0; i < 400; i++) begin
            rr = {3'($urandom % 3), 3'd0, 3'($urandom % 8)};
            if ($urandom % 5 == 0) begin
                do_fill(rr, 2'($urandom), 6'($urandom));
            end else begin
                logic [1:0] bb;
                bb = 2'($urandom);
                tx = ($urandom % 2 == 0) ? dmeta[rr][bb*7 +: 6] : 6'($urandom);
                do_req(mk_addr(tx, rr, bb, 7'($urandom)), 1'($urandom));
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule